// File: doc/BRIEF.md
# Per-Port Ethernet Statistics Counter Bank

This block holds the frame statistics of a seven-port Ethernet switch. Each port owns a fixed set of counters for received and transmitted traffic: broadcast, pause and multicast frames, seven frame-size buckets, error and collision conditions, and running byte totals. The MAC side delivers already classified events as one-cycle strobes. The three byte counters also take a frame length that is added on each strobe.

Software reads every counter through a 32-bit register read port. Each port has its own 256-byte address window. The narrow counters are 32 bits wide and wrap without saturating. The byte counters are 64 bits wide and read as a low word followed by a high word.

A control register starts a flush. The flush walks through every counter word of every port, one word per clock, and a busy flag stays set until the walk ends. A separate enable register gates all counting.

Top module: `stats_bank`

## Requirements
- R1: After reset every counter reads zero. The control register at 0x0080 reads zero, and the enable register at 0x0084 reads zero, so counting is off.
- R2: Port p's counters sit in a window starting at 0x1000 + 0x100*p, for p = 0..6. The read data for rd_addr_i appears on rd_data_o one clock after the address is sampled.
- R3: Receive event index e = 0..14 increments the 32-bit counter at window offset 4*e by one per strobe. Event e of port p is evt_i bit p*37+e. Indices 0..14 are, in order: broadcast, pause, multicast, FCS error, alignment error, runt, fragment, the 64/128/256/512/1024/1518/max size buckets, and too-long.
- R4: Transmit events e = 17..28 count at offset 4*(e+4), which covers 0x54..0x80: broadcast, pause, multicast, underrun, the seven size buckets, and oversize. Events e = 30..36 count at offset 4*(e+5), which covers 0x8c..0xa4: collision, abort-collision, multi-collision, single-collision, excessive-defer, defer, and late-collision.
- R5: The byte counters are 64 bits wide, with the low word at the listed offset and the high word at offset +4. The carry passes from the low word into the high word. Event 15 adds the port's rx_len_i at 0x3c. Event 16 adds rx_len_i at 0x44. Event 29 adds the port's tx_len_i at 0x84.
- R6: Counters advance only while bit 0 of the enable register (0x0084) is 1. The bit reads back at bit 0.
- R7: A write to 0x0080 with bit 31 and bit 24 both set starts a flush. A write with only one of the two bits set starts nothing. Bit 31 of 0x0080 reads as the busy flag.
- R8: Busy stays at 1 for exactly 280 clocks (7 ports x 40 counter words). The flush clears one word per clock, in ascending port order and ascending offset order within a port. After the flush every counter reads zero.
- R9: Event strobes that arrive while busy is 1 are dropped.
- R10: The following read zero: offsets 0x4c, 0x50, 0xa8 and 0xac, offsets above 0xac inside a window, and any address that is neither a window nor one of the two registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_PORTS*37 | Event strobes; bit p*37+e is event e of port p |
| rx_len_i | input | NUM_PORTS*LEN_W | Per-port receive frame length for the receive byte counters |
| tx_len_i | input | NUM_PORTS*LEN_W | Per-port transmit frame length for the transmit byte counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | ADDR_W | Read address, sampled every clock |
| rd_data_o | output | 32 | Registered read data |

## Verification
The hardest state to reach from the ports is a carry out of a byte counter's low word, because the low word must pass 2^32. The bench gets there by strobing one port's good-byte event for 65538 consecutive cycles at the largest frame length, 65535. It then expects a low word of 65534 and a high word of 1. A second hard case is a flush that runs while events keep arriving and reads keep landing on words both before and after the point the clear walk has reached. The bench checks this case against a model that clears words in address order, one per clock.

// File: rtl/stats_bank_pkg.sv
package stats_bank_pkg;
  localparam int NUM_EVT        = 37;
  localparam int WORDS_PER_PORT = 40;
  localparam int SLOT_W         = 6;
  localparam int GAP_AT         = 19;
  localparam int GAP_LEN        = 2;

  localparam int EV_RX_GOODB = 15;
  localparam int EV_RX_BADB  = 16;
  localparam int EV_TX_BYTES = 29;

  // word slot (offset/4) of the low word of event e
  function automatic int evt_slot(int e);
    if (e <= EV_RX_GOODB)      return e;
    else if (e == EV_RX_BADB)  return 17;
    else if (e < EV_TX_BYTES)  return e + 4;
    else if (e == EV_TX_BYTES) return 33;
    else                       return e + 5;
  endfunction

  function automatic bit evt_wide(int e);
    return (e == EV_RX_GOODB) || (e == EV_RX_BADB) || (e == EV_TX_BYTES);
  endfunction

  // k-th implemented counter word of a window -> word slot
  function automatic logic [SLOT_W-1:0] word_slot(logic [SLOT_W-1:0] k);
    return (k < SLOT_W'(GAP_AT)) ? k : k + SLOT_W'(GAP_LEN);
  endfunction
endpackage

// File: rtl/stats_ctr.sv
module stats_ctr #(
  parameter bit WIDE  = 1'b0,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] amt_i,
  input  logic             clr_lo_i,
  input  logic             clr_hi_i,
  output logic [63:0]      val_o
);
  logic [31:0] lo_q, lo_d;
  logic        lo_en;

  assign lo_en = inc_i | clr_lo_i;

  if (WIDE) begin : g_wide
    logic [31:0] hi_q, hi_d;
    logic [63:0] sum;
    logic        hi_en;

    assign hi_en = inc_i | clr_hi_i;

    always_comb begin
      sum  = {hi_q, lo_q} + 64'(amt_i);
      lo_d = inc_i ? sum[31:0]  : lo_q;
      hi_d = inc_i ? sum[63:32] : hi_q;
      if (clr_lo_i) lo_d = '0;
      if (clr_hi_i) hi_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= '0;
      else if (hi_en) hi_q <= hi_d;
    end

    assign val_o = {hi_q, lo_q};

    assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_lo_i && !clr_hi_i) |=> val_o == $past(val_o) + 64'($past(amt_i)));
  end else begin : g_narrow
    logic unused_in;
    assign unused_in = ^{amt_i, clr_hi_i};

    always_comb begin
      lo_d = inc_i ? lo_q + 32'd1 : lo_q;
      if (clr_lo_i) lo_d = '0;
    end

    assign val_o = {32'd0, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_lo_i && !clr_hi_i) |=> $stable(val_o));

  assert_clear_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo_i |=> val_o[31:0] == 32'd0);
endmodule

// File: rtl/stats_port.sv
module stats_port
  import stats_bank_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [LEN_W-1:0]   rx_len_i,
  input  logic [LEN_W-1:0]   tx_len_i,
  input  logic               count_en_i,
  input  logic               clr_en_i,
  input  logic [SLOT_W-1:0]  clr_slot_i,
  input  logic [SLOT_W-1:0]  rd_slot_i,
  output logic [31:0]        rd_word_o
);
  logic [63:0] val [NUM_EVT];

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_ctr
    localparam int SL = evt_slot(e);
    localparam bit WD = evt_wide(e);
    logic             clr_lo, clr_hi;
    logic [LEN_W-1:0] amt;

    assign clr_lo = clr_en_i && (clr_slot_i == SLOT_W'(SL));
    assign clr_hi = WD && clr_en_i && (clr_slot_i == SLOT_W'(SL + 1));
    assign amt    = (e == EV_TX_BYTES) ? tx_len_i : rx_len_i;

    stats_ctr #(.WIDE(WD), .LEN_W(LEN_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (count_en_i && evt_i[e]),
      .amt_i    (amt),
      .clr_lo_i (clr_lo),
      .clr_hi_i (clr_hi),
      .val_o    (val[e])
    );
  end

  always_comb begin
    rd_word_o = '0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (rd_slot_i == SLOT_W'(evt_slot(e))) rd_word_o = val[e][31:0];
      if (evt_wide(e) && (rd_slot_i == SLOT_W'(evt_slot(e) + 1))) rd_word_o = val[e][63:32];
    end
  end
endmodule

// File: rtl/stats_flush.sv
module stats_flush
  import stats_bank_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int PW        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic [PW-1:0]     port_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST_WORD = SLOT_W'(WORDS_PER_PORT - 1);
  localparam logic [PW-1:0]     LAST_PORT = PW'(NUM_PORTS - 1);
  localparam int                TOTAL     = NUM_PORTS * WORDS_PER_PORT;

  logic              busy_q, busy_d;
  logic [PW-1:0]     port_q, port_d;
  logic [SLOT_W-1:0] word_q, word_d;
  logic              step_en;

  always_comb begin
    busy_d = busy_q;
    port_d = port_q;
    word_d = word_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        port_d = '0;
        word_d = '0;
      end
    end else if (word_q == LAST_WORD) begin
      word_d = '0;
      if (port_q == LAST_PORT) busy_d = 1'b0;
      else                     port_d = port_q + PW'(1);
    end else begin
      word_d = word_q + SLOT_W'(1);
    end
  end

  assign step_en = busy_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      port_q <= '0;
      word_q <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      port_q <= port_d;
      word_q <= word_d;
    end
  end

  assign busy_o = busy_q;
  assign port_o = port_q;
  assign slot_o = word_slot(word_q);

  // checker: length of each busy window
  logic [15:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   chk_len <= '0;
    else if (!busy_q && start_i)  chk_len <= '0;
    else if (busy_q)              chk_len <= chk_len + 16'd1;
  end

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> chk_len == 16'(TOTAL));

  assert_walk_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (port_q <= LAST_PORT) && (word_q <= LAST_WORD));
endmodule

// File: rtl/stats_bank.sv
module stats_bank
  import stats_bank_pkg::*;
#(
  parameter int              NUM_PORTS = 7,
  parameter int              LEN_W     = 16,
  parameter int              ADDR_W    = 16,
  parameter int              WIN_LG    = 8,
  parameter logic [15:0]     BASE_ADDR = 16'h1000,
  parameter logic [15:0]     CTRL_ADDR = 16'h0080,
  parameter logic [15:0]     ENA_ADDR  = 16'h0084,
  parameter int              BUSY_BIT  = 31,
  parameter int              FLUSH_BIT = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PORTS*NUM_EVT-1:0] evt_i,
  input  logic [NUM_PORTS*LEN_W-1:0]   rx_len_i,
  input  logic [NUM_PORTS*LEN_W-1:0]   tx_len_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [31:0]                  wr_data_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [31:0]                  rd_data_o
);
  localparam int              PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(NUM_PORTS << WIN_LG);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] ENA_A    = ADDR_W'(ENA_ADDR);

  logic              ena_q, ena_d, ena_en;
  logic              flush_start, busy;
  logic [PW-1:0]     flush_port;
  logic [SLOT_W-1:0] flush_slot;
  logic              count_en;
  logic unused_wr;

  assign unused_wr = ^wr_data_i;

  // register writes
  assign ena_en      = wr_en_i && (wr_addr_i == ENA_A);
  assign ena_d       = wr_data_i[0];
  assign flush_start = wr_en_i && (wr_addr_i == CTRL_A) &&
                       wr_data_i[BUSY_BIT] && wr_data_i[FLUSH_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= 1'b0;
    else if (ena_en) ena_q <= ena_d;
  end

  assign count_en = ena_q && !busy;

  stats_flush #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (flush_start),
    .busy_o  (busy),
    .port_o  (flush_port),
    .slot_o  (flush_slot)
  );

  // read address decode
  logic [ADDR_W-1:0] rel;
  logic              in_win;
  logic [PW-1:0]     rd_port;
  logic [SLOT_W-1:0] rd_slot;

  assign rel     = rd_addr_i - BASE_A;
  assign in_win  = (rd_addr_i >= BASE_A) && (rel < WIN_SPAN);
  assign rd_port = rel[WIN_LG +: PW];
  assign rd_slot = rel[WIN_LG-1:2];

  logic [31:0] port_word [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    stats_port #(.LEN_W(LEN_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i[p*NUM_EVT +: NUM_EVT]),
      .rx_len_i   (rx_len_i[p*LEN_W +: LEN_W]),
      .tx_len_i   (tx_len_i[p*LEN_W +: LEN_W]),
      .count_en_i (count_en),
      .clr_en_i   (busy && (flush_port == PW'(p))),
      .clr_slot_i (flush_slot),
      .rd_slot_i  (rd_slot),
      .rd_word_o  (port_word[p])
    );
  end

  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (rd_addr_i == CTRL_A) begin
      rd_next[BUSY_BIT] = busy;
    end else if (rd_addr_i == ENA_A) begin
      rd_next[0] = ena_q;
    end else if (in_win) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (rd_port == PW'(p)) rd_next = port_word[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else        rd_data_o <= rd_next;
  end

  assert_flush_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en_i && (wr_addr_i == CTRL_A) &&
                          wr_data_i[BUSY_BIT] && wr_data_i[FLUSH_BIT]));

  assert_outside_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win && (rd_addr_i != CTRL_A) && (rd_addr_i != ENA_A)) |=> rd_data_o == 32'd0);

  assert_busy_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == CTRL_A) |=> rd_data_o[BUSY_BIT] == $past(busy));
endmodule

// File: tb/stats_bank_tb.sv
module stats_bank_tb;
  localparam int NP = 7;
  localparam int NE = 37;
  localparam int LW = 16;
  localparam logic [15:0] CTRL = 16'h0080;
  localparam logic [15:0] ENA  = 16'h0084;
  localparam int FLUSH_WORDS = NP * 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [NP*NE-1:0]  evt;
  logic [NP*LW-1:0]  rxl, txl;
  logic              wr_en;
  logic [15:0]       wr_addr, rd_addr;
  logic [31:0]       wr_data, rd_data;

  stats_bank u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rx_len_i(rxl), .tx_len_i(txl),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model: one 32-bit word per address slot
  logic [31:0] mw [NP][64];
  bit          m_busy, m_ena;
  int          m_idx;
  logic [31:0] exp_rd;
  logic [15:0] exp_addr;
  bit          cmp_on = 0;
  string       ptag = "";

  function automatic int slot_of(int e);
    case (1'b1)
      (e < 15):  return e;
      (e == 15): return 15;
      (e == 16): return 17;
      (e < 29):  return 21 + (e - 17);
      (e == 29): return 33;
      default:   return 35 + (e - 30);
    endcase
  endfunction

  function automatic bit is_wide(int e);
    return e == 15 || e == 16 || e == 29;
  endfunction

  function automatic logic [31:0] mread(logic [15:0] a);
    int p, off;
    if (a == CTRL) return {m_busy, 31'd0};
    if (a == ENA)  return {31'd0, m_ena};
    if (a < 16'h1000 || a >= 16'h1000 + NP*256) return 32'd0;
    p   = (int'(a) - 'h1000) / 256;
    off = (int'(a) - 'h1000) % 256;
    if (off > 'hac) return 32'd0;
    return mw[p][off/4];
  endfunction

  function automatic string tag_of(logic [15:0] a);
    int off, s;
    if (ptag != "") return ptag;
    if (a == CTRL) return "R7";
    if (a == ENA)  return "R6";
    if (a < 16'h1000 || a >= 16'h1000 + NP*256) return "R10";
    off = (int'(a) - 'h1000) % 256;
    s = off / 4;
    if (off > 'hac || s == 19 || s == 20 || s == 42 || s == 43) return "R10";
    if (s >= 15 && s <= 18) return "R5";
    if (s == 33 || s == 34) return "R5";
    if (s < 15) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [15:0] a, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h act=%h exp=%h", tag, a, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++)
        for (int s = 0; s < 64; s++) mw[p][s] = 32'd0;
      m_busy = 0; m_ena = 0; m_idx = 0;
      exp_rd = 32'd0; exp_addr = rd_addr;
    end else begin
      bit b0;
      b0 = m_busy;
      exp_rd   = mread(rd_addr);
      exp_addr = rd_addr;
      if (b0) begin
        int w;
        w = m_idx % 40;
        mw[m_idx / 40][(w < 19) ? w : w + 2] = 32'd0;
        m_idx++;
        if (m_idx == FLUSH_WORDS) m_busy = 0;
      end else if (m_ena) begin
        for (int p = 0; p < NP; p++)
          for (int e = 0; e < NE; e++)
            if (evt[p*NE + e]) begin
              int s;
              s = slot_of(e);
              if (is_wide(e)) begin
                logic [63:0] v;
                v = {mw[p][s+1], mw[p][s]} +
                    64'((e == 29) ? txl[p*LW +: LW] : rxl[p*LW +: LW]);
                mw[p][s] = v[31:0];
                mw[p][s+1] = v[63:32];
              end else begin
                mw[p][s] = mw[p][s] + 32'd1;
              end
            end
      end
      if (wr_en && wr_addr == ENA) m_ena = wr_data[0];
      if (wr_en && wr_addr == CTRL && wr_data[31] && wr_data[24] && !b0) begin
        m_busy = 1; m_idx = 0;
      end
    end
  end

  always @(negedge clk)
    if (cmp_on) check(tag_of(exp_addr), exp_addr, rd_data, exp_rd);

  // stimulus helpers, all driven at the falling edge
  task automatic write_reg(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic read_chk(logic [15:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(tag, a, rd_data, exp);
  endtask

  task automatic rand_events(int density);
    for (int i = 0; i < NP*NE; i++) evt[i] = ($urandom_range(0, density) == 0);
    for (int i = 0; i < NP*LW; i++) begin
      rxl[i] = $urandom_range(0, 1);
      txl[i] = $urandom_range(0, 1);
    end
  endtask

  function automatic logic [15:0] sweep_addr(int k);
    int m;
    m = k % 53;
    if (m == 50) return CTRL;
    if (m == 51) return ENA;
    if (m == 52) return 16'h1700 + 16'(k % 5) * 4;
    return 16'h1000 + 16'((k / 53) % NP) * 256 + 16'(m) * 4;
  endfunction

  task automatic run_random(int n, int density, bit quiet_end);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rand_events(density);
      rd_addr = sweep_addr(k + $urandom_range(0, 3));
    end
    if (quiet_end) begin
      @(negedge clk);
      evt = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    rst_n = 0; evt = '0; rxl = '0; txl = '0;
    wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = 16'h1000;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;

    // R1: reset state
    read_chk(CTRL, 32'd0, "R1");
    read_chk(ENA, 32'd0, "R1");
    read_chk(16'h1000, 32'd0, "R1");
    read_chk(16'h1684, 32'd0, "R1");

    // R6: events with counting disabled
    ptag = "R6";
    run_random(120, 2, 1);
    read_chk(16'h1000, 32'd0, "R6");
    read_chk(16'h123c, 32'd0, "R6");
    ptag = "";

    write_reg(ENA, 32'd1);
    read_chk(ENA, 32'd1, "R6");

    // R2: window placement, port 6 late collision and port 0 broadcast
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      evt = '0; evt[6*NE + 36] = 1'b1;
      if (i == 0) evt[0] = 1'b1;
    end
    @(negedge clk);
    evt = '0;
    read_chk(16'h16a4, 32'd3, "R2");
    read_chk(16'h1000, 32'd1, "R2");
    read_chk(16'h10a4, 32'd0, "R2");
    read_chk(16'h1600, 32'd0, "R2");

    // R3/R4/R5: random traffic compared every cycle
    run_random(3000, 5, 1);
    run_random(1500, 1, 1);

    // R5: carry from low into high word of port 3 good bytes
    write_reg(CTRL, 32'h8100_0000);
    repeat (FLUSH_WORDS + 4) @(negedge clk);
    ptag = "R5";
    @(negedge clk);
    evt = '0; evt[3*NE + 15] = 1'b1;
    rxl[3*LW +: LW] = 16'hffff;
    for (int k = 0; k < 65538; k++) begin
      rd_addr = (k % 2 == 0) ? 16'h133c : 16'h1340;
      if (k != 65537) @(negedge clk);
    end
    @(negedge clk);
    evt = '0;
    read_chk(16'h133c, 32'd65534, "R5");
    read_chk(16'h1340, 32'd1, "R5");
    read_chk(16'h1344, 32'd0, "R5");
    ptag = "";

    // R7: one bit alone does not start a flush
    write_reg(CTRL, 32'h0100_0000);
    read_chk(CTRL, 32'd0, "R7");
    write_reg(CTRL, 32'h8000_0000);
    read_chk(CTRL, 32'd0, "R7");
    read_chk(16'h133c, 32'd65534, "R7");

    // R8: busy duration
    @(negedge clk);
    rd_addr = CTRL; wr_en = 1; wr_addr = CTRL; wr_data = 32'h8100_0000;
    @(negedge clk);
    wr_en = 0;
    busy_cnt = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (rd_data[31]) busy_cnt++;
      else break;
    end
    checks++;
    if (busy_cnt != FLUSH_WORDS) begin
      fails++;
      $display("FAIL R8 busy cycles act=%0d exp=%0d", busy_cnt, FLUSH_WORDS);
    end
    read_chk(16'h133c, 32'd0, "R8");
    read_chk(16'h1340, 32'd0, "R8");
    read_chk(16'h16a4, 32'd0, "R8");

    // R9: traffic during a flush, reads landing on both sides of the walk
    run_random(400, 3, 1);
    ptag = "R9";
    @(negedge clk);
    wr_en = 1; wr_addr = CTRL; wr_data = 32'h8100_0000;
    @(negedge clk);
    wr_en = 0;
    run_random(270, 1, 1);
    repeat (20) @(negedge clk);
    read_chk(16'h1000, 32'd0, "R9");
    read_chk(16'h1484, 32'd0, "R9");
    read_chk(16'h1534, 32'd0, "R9");
    ptag = "";

    // R10: holes and out-of-range addresses after traffic
    run_random(600, 1, 1);
    read_chk(16'h104c, 32'd0, "R10");
    read_chk(16'h1250, 32'd0, "R10");
    read_chk(16'h10a8, 32'd0, "R10");
    read_chk(16'h16ac, 32'd0, "R10");
    read_chk(16'h10fc, 32'd0, "R10");
    read_chk(16'h1700, 32'd0, "R10");
    read_chk(16'h0ffc, 32'd0, "R10");

    // R6: disable again, traffic must not move counters
    write_reg(ENA, 32'd0);
    ptag = "R6";
    run_random(300, 1, 1);
    ptag = "";

    repeat (3) @(negedge clk);
    cmp_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule